// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block sits beside one processor and keeps track of a configurable number of interrupt vectors (256 by default). It holds three bitmaps as a set of 32-bit words: vectors waiting for service, vectors in service, and how each vector was last raised (level or edge). It also holds an 8-bit task priority and a 9-bit spurious/enable register. From this state it decides whether to signal the processor and which vector to hand over.

Vectors are ranked by number, and the highest-numbered one wins. Priority is compared in classes of 16 vectors, which are the upper four bits of the vector number. The processor priority is the higher of two values: the task priority, or the class of the most urgent vector in service.

When the processor acknowledges, it receives either the winning pending vector, which moves to in-service, or the programmed spurious vector. An end-of-interrupt write retires the most urgent in-service vector. A flat register port gives read access to every register and bitmap word, and write access to the task, spurious and end-of-interrupt locations.

Top module: `vec_prio_arbiter`

## Requirements
- R1: After reset, the task priority reads 0, the spurious register reads 0x0FF (enable bit 8 clear), every bitmap word reads 0, and `irq` is low.
- R2: Register addresses are as follows. 0 is the task priority (read/write). 1 is the spurious register (read/write). 2 is the processor priority (read-only). 3 is end-of-interrupt (write-only; reads 0). 8+w is pending word w. 16+w is in-service word w. 24+w is trigger word w. Vector v lives in word v/32 at bit v%32.
- R3: A task-priority write keeps data bits 7:0. A spurious write keeps data bits 8:0.
- R4: `irq` is a register. One clock edge after the state changes, it is high exactly when all of these hold: spurious bit 8 is set, some vector is pending, and either the processor priority is 0 or the top pending vector's class is strictly greater than the processor priority's class.
- R5: A request sets the vector's pending bit. It sets the vector's trigger bit when `req_level` is 1 and clears it when `req_level` is 0.
- R6: An accepted acknowledge returns the highest-numbered pending vector on `ack_vec` in the same cycle. It clears that vector's pending bit and sets its in-service bit.
- R7: An acknowledge is refused when any of these holds: spurious bit 8 is clear, nothing is pending, or the task priority is nonzero and the top pending vector is less than or equal to the full task priority. A refused acknowledge returns spurious bits 7:0 and changes no bitmap.
- R8: An end-of-interrupt write clears only the highest-numbered in-service bit. With nothing in service it changes nothing.
- R9: The processor priority equals the task priority when the task class is greater than or equal to the class of the top in-service vector (class 0 when none is in service). Otherwise it equals that in-service class followed by four zero bits.
- R10: A request and an acknowledge in the same cycle act as if the request were logged first. The new vector can be the one acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Log a vector request this cycle |
| req_vec | input | VEC_W | Requested vector number |
| req_level | input | 1 | 1 = level request, 0 = edge request |
| ack | input | 1 | One-cycle acknowledge strobe from the processor |
| ack_vec | output | VEC_W | Vector returned for the acknowledge, valid in the strobe cycle |
| irq | output | 1 | Registered interrupt line to the processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | WORD_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | WORD_W | Register read data (combinational) |

## Verification
Each kind of corrupted state shows up at the ports within a cycle or two. A wrong pending bitmap or a wrong winner choice appears at once on `ack_vec`, in the same cycle as the acknowledge strobe. A wrong class comparison or a wrong processor priority appears one edge later, as `irq` taking the wrong value, and can also be read directly at address 2. A retirement that clears the wrong in-service bit shows in the next processor-priority read and in the in-service words. A refused acknowledge that still touches state shows in the pending words read afterwards.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
   // control locations inside register group 0
   localparam int unsigned CTL_TASK = 0;
   localparam int unsigned CTL_SPUR = 1;
   localparam int unsigned CTL_PPR  = 2;
   localparam int unsigned CTL_EOI  = 3;

   // register groups selected by the upper address bits
   typedef enum logic [1:0] {
      GRP_CTL  = 2'd0,
      GRP_PEND = 2'd1,
      GRP_SERV = 2'd2,
      GRP_TRIG = 2'd3
   } grp_e;
endpackage

// File: rtl/vpa_hifind.sv
// Highest-set-bit finder, built as per-group encoders and a group selector.
module vpa_hifind #(
   parameter int unsigned W   = 256,
   parameter int unsigned GRP = 32,
   parameter int unsigned IW  = $clog2(W)
) (
   input  logic [W-1:0]  map,
   output logic          any,
   output logic [IW-1:0] idx
);
   localparam int unsigned NG = W / GRP;
   localparam int unsigned GW = $clog2(GRP);

   generate
      if (W % GRP != 0) begin : g_bad_split
         $error("vpa_hifind: W must be a multiple of GRP");
      end
      if (IW != $clog2(W)) begin : g_bad_iw
         $error("vpa_hifind: IW must equal clog2(W)");
      end
   endgenerate

   logic [NG-1:0]    g_any;
   logic [NG*GW-1:0] g_idx;

   generate
      for (genvar g = 0; g < NG; g++) begin : g_grp
         logic [GW-1:0] loc;
         always_comb begin
            loc = '0;
            for (int b = 0; b < GRP; b++) begin
               if (map[g*GRP + b]) loc = GW'(b);
            end
         end
         assign g_any[g]            = |map[g*GRP +: GRP];
         assign g_idx[g*GW +: GW]   = loc;
      end

      if (NG == 1) begin : g_single
         assign any = g_any[0];
         assign idx = g_idx;
      end else begin : g_multi
         localparam int unsigned SW = $clog2(NG);
         logic [SW-1:0] sel;
         always_comb begin
            sel = '0;
            for (int g = 0; g < NG; g++) begin
               if (g_any[g]) sel = SW'(g);
            end
         end
         assign any = |g_any;
         assign idx = {sel, g_idx[sel*GW +: GW]};
      end
   endgenerate
endmodule

// File: rtl/vpa_ppr.sv
// Processor priority from task priority and the top in-service vector.
module vpa_ppr #(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned CLS_LSB = 4
) (
   input  logic [VEC_W-1:0] tpr,
   input  logic             serv_any,
   input  logic [VEC_W-1:0] serv_top,
   output logic [VEC_W-1:0] ppr
);
   localparam int unsigned CW = VEC_W - CLS_LSB;

   generate
      if (CLS_LSB >= VEC_W) begin : g_bad_cls
         $error("vpa_ppr: class split must leave class bits");
      end
   endgenerate

   logic [CW-1:0] cls_task;
   logic [CW-1:0] cls_serv;

   always_comb begin
      cls_task = tpr[VEC_W-1:CLS_LSB];
      cls_serv = serv_any ? serv_top[VEC_W-1:CLS_LSB] : '0;
      ppr      = (cls_task >= cls_serv) ? tpr : {cls_serv, {CLS_LSB{1'b0}}};
   end
endmodule

// File: rtl/vec_prio_arbiter.sv
module vec_prio_arbiter #(
   parameter int unsigned NUM_VEC = 256,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned CLS_LSB = 4,
   parameter int unsigned VEC_W   = $clog2(NUM_VEC),
   parameter int unsigned ADDR_W  = $clog2(4 * (NUM_VEC / WORD_W))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VEC_W-1:0]  req_vec,
   input  logic              req_level,
   input  logic              ack,
   output logic [VEC_W-1:0]  ack_vec,
   output logic              irq,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   import vpa_pkg::*;

   localparam int unsigned NW     = NUM_VEC / WORD_W;
   localparam int unsigned WSEL_W = $clog2(NW);
   localparam int unsigned SP_W   = VEC_W + 1;
   localparam int unsigned CW     = VEC_W - CLS_LSB;
   localparam logic [SP_W-1:0] SPUR_RST = {1'b0, {VEC_W{1'b1}}};

   generate
      if (NUM_VEC % WORD_W != 0) begin : g_bad_words
         $error("vec_prio_arbiter: NUM_VEC must be a multiple of WORD_W");
      end
      if ((1 << VEC_W) != NUM_VEC) begin : g_bad_vec
         $error("vec_prio_arbiter: NUM_VEC must be a power of two matching VEC_W");
      end
      if (NW < 4) begin : g_bad_nw
         $error("vec_prio_arbiter: need at least four words for control slots");
      end
      if (SP_W > WORD_W) begin : g_bad_spw
         $error("vec_prio_arbiter: spurious register wider than a word");
      end
      if (ADDR_W != WSEL_W + 2) begin : g_bad_addr
         $error("vec_prio_arbiter: ADDR_W must hold four word groups");
      end
   endgenerate

   // state
   logic [NUM_VEC-1:0] pend_q, serv_q, trig_q;
   logic [VEC_W-1:0]   tpr_q;
   logic [SP_W-1:0]    spur_q;
   logic               irq_q;

   // request and effective pending map (request applied before acknowledge)
   logic [NUM_VEC-1:0] req_bit, pend_eff;
   assign req_bit  = req_valid ? (NUM_VEC'(1) << req_vec) : '0;
   assign pend_eff = pend_q | req_bit;

   // encoders
   logic             pe_any, sv_any, pq_any;
   logic [VEC_W-1:0] pe_top, sv_top, pq_top;

   vpa_hifind #(.W(NUM_VEC), .GRP(WORD_W), .IW(VEC_W)) u_find_eff (
      .map(pend_eff), .any(pe_any), .idx(pe_top));
   vpa_hifind #(.W(NUM_VEC), .GRP(WORD_W), .IW(VEC_W)) u_find_serv (
      .map(serv_q), .any(sv_any), .idx(sv_top));
   vpa_hifind #(.W(NUM_VEC), .GRP(WORD_W), .IW(VEC_W)) u_find_pend (
      .map(pend_q), .any(pq_any), .idx(pq_top));

   logic [VEC_W-1:0] ppr;
   vpa_ppr #(.VEC_W(VEC_W), .CLS_LSB(CLS_LSB)) u_ppr (
      .tpr(tpr_q), .serv_any(sv_any), .serv_top(sv_top), .ppr(ppr));

   // acknowledge decision
   logic enabled, refuse, ack_take;
   assign enabled  = spur_q[VEC_W];
   assign refuse   = !enabled || !pe_any || ((tpr_q != '0) && (pe_top <= tpr_q));
   assign ack_take = ack && !refuse;
   assign ack_vec  = refuse ? spur_q[VEC_W-1:0] : pe_top;

   // register write decode
   logic [1:0]        wr_grp;
   logic [WSEL_W-1:0] wr_word;
   logic              wr_task, wr_spur, eoi;
   assign wr_grp  = wr_addr[ADDR_W-1:WSEL_W];
   assign wr_word = wr_addr[WSEL_W-1:0];
   assign wr_task = wr_en && (wr_grp == GRP_CTL) && (wr_word == WSEL_W'(CTL_TASK));
   assign wr_spur = wr_en && (wr_grp == GRP_CTL) && (wr_word == WSEL_W'(CTL_SPUR));
   assign eoi     = wr_en && (wr_grp == GRP_CTL) && (wr_word == WSEL_W'(CTL_EOI));

   logic [WORD_W-SP_W-1:0] wr_hi_unused;
   assign wr_hi_unused = wr_data[WORD_W-1:SP_W];

   // next state
   logic [NUM_VEC-1:0] take_bit, eoi_bit, pend_d, serv_d, trig_d;
   always_comb begin
      take_bit = ack_take ? (NUM_VEC'(1) << pe_top) : '0;
      eoi_bit  = (eoi && sv_any) ? (NUM_VEC'(1) << sv_top) : '0;
      pend_d   = pend_eff & ~take_bit;
      serv_d   = (serv_q & ~eoi_bit) | take_bit;
      if (req_valid) trig_d = req_level ? (trig_q | req_bit) : (trig_q & ~req_bit);
      else           trig_d = trig_q;
   end

   // interrupt line evaluation on present state
   logic [CW-1:0]      pq_cls_unused_lo;
   logic               irq_d;
   assign pq_cls_unused_lo = pq_top[VEC_W-1:CLS_LSB];
   assign irq_d = enabled && pq_any &&
                  ((ppr == '0) || (pq_top[VEC_W-1:CLS_LSB] > ppr[VEC_W-1:CLS_LSB]));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         serv_q <= '0;
         trig_q <= '0;
         tpr_q  <= '0;
         spur_q <= SPUR_RST;
         irq_q  <= 1'b0;
      end else begin
         pend_q <= pend_d;
         serv_q <= serv_d;
         trig_q <= trig_d;
         if (wr_task) tpr_q  <= wr_data[VEC_W-1:0];
         if (wr_spur) spur_q <= wr_data[SP_W-1:0];
         irq_q  <= irq_d;
      end
   end
   assign irq = irq_q;

   // register read
   logic [1:0]        rd_grp;
   logic [WSEL_W-1:0] rd_word;
   assign rd_grp  = rd_addr[ADDR_W-1:WSEL_W];
   assign rd_word = rd_addr[WSEL_W-1:0];

   always_comb begin
      rd_data = '0;
      case (rd_grp)
         GRP_CTL: begin
            if      (rd_word == WSEL_W'(CTL_TASK)) rd_data = WORD_W'(tpr_q);
            else if (rd_word == WSEL_W'(CTL_SPUR)) rd_data = WORD_W'(spur_q);
            else if (rd_word == WSEL_W'(CTL_PPR))  rd_data = WORD_W'(ppr);
         end
         GRP_PEND: rd_data = pend_q[rd_word*WORD_W +: WORD_W];
         GRP_SERV: rd_data = serv_q[rd_word*WORD_W +: WORD_W];
         default:  rd_data = trig_q[rd_word*WORD_W +: WORD_W];
      endcase
   end

   // assertions
   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(spur_q[VEC_W])); // R4
   AST_REQ_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (pend_q[$past(req_vec)] || serv_q[$past(req_vec)])); // R5
   AST_LEVEL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_level) |=> trig_q[$past(req_vec)]); // R5
   AST_TAKE_FILLS_SERV: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> (serv_q != '0)); // R6
   AST_REFUSE_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !ack_take && !req_valid) |=> $stable(pend_q)); // R7
   AST_EOI_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !sv_any && !ack_take) |=> (serv_q == '0)); // R8
   AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      ppr >= tpr_q); // R9
endmodule

// File: tb/test_vec_prio_arbiter.sv
module test_vec_prio_arbiter;
   localparam int CLK_P = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        req_valid = 0;
   logic [7:0]  req_vec = 0;
   logic        req_level = 0;
   logic        ack = 0;
   logic [7:0]  ack_vec;
   logic        irq;
   logic        wr_en = 0;
   logic [4:0]  wr_addr = 0;
   logic [31:0] wr_data = 0;
   logic [4:0]  rd_addr = 0;
   logic [31:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   vec_prio_arbiter i_vec_prio_arbiter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
      .req_level(req_level), .ack(ack), .ack_vec(ack_vec), .irq(irq),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data));

   // table: {task priority, request vector, expected irq, expected ack vector}
   // spurious vector programmed to 0x0F
   localparam logic [31:0] TBL [8] = '{
      {8'h00, 8'h41, 8'h01, 8'h41},
      {8'h40, 8'h41, 8'h00, 8'h41},
      {8'h40, 8'h40, 8'h00, 8'h0F},
      {8'h3F, 8'h50, 8'h01, 8'h50},
      {8'h5A, 8'h5B, 8'h00, 8'h5B},
      {8'hF0, 8'hFF, 8'h00, 8'hFF},
      {8'h10, 8'h0A, 8'h00, 8'h0F},
      {8'h00, 8'h00, 8'h01, 8'h00}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(posedge clk); #1 wr_en = 0;
   endtask

   task automatic post(input logic [7:0] v, input logic lvl);
      @(negedge clk); req_valid = 1; req_vec = v; req_level = lvl;
      @(posedge clk); #1 req_valid = 0;
   endtask

   task automatic take(output logic [7:0] v);
      @(negedge clk); ack = 1; #1 v = ack_vec;
      @(posedge clk); #1 ack = 0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); rd_addr = a; #1 d = rd_data;
   endtask

   task automatic settle();
      @(posedge clk); #1;
   endtask

   initial begin
      #(CLK_P * 50000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset state
      rd(5'd0, d);  chk("R1 task prio", d, 32'h0);
      rd(5'd1, d);  chk("R1 spurious", d, 32'h0FF);
      for (int w = 0; w < 8; w++) begin
         rd(5'(8 + w), d);  chk("R1 pending word", d, 32'h0);
         rd(5'(16 + w), d); chk("R1 service word", d, 32'h0);
      end
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // R4/R7 disabled: no irq, spurious returned, pending kept
      post(8'h70, 1'b0); settle();
      chk("R4 irq disabled", {31'h0, irq}, 32'h0);
      take(v); chk("R7 ack disabled", {24'h0, v}, 32'hFF);
      rd(5'd11, d); chk("R7 pending kept", d, 32'h0001_0000);
      wr(5'd1, 32'h10F); settle();
      chk("R4 irq after enable", {31'h0, irq}, 32'h1);
      take(v); chk("R6 ack 0x70", {24'h0, v}, 32'h70);
      wr(5'd3, 0);

      // table walk: R4 class compare, R6/R7 acknowledge decisions
      for (int i = 0; i < 8; i++) begin
         wr(5'd0, {24'h0, TBL[i][31:24]});
         post(TBL[i][23:16], 1'b0); settle();
         chk("R4 table irq", {31'h0, irq}, {31'h0, TBL[i][8]});
         take(v); chk("R6/R7 table ack", {24'h0, v}, {24'h0, TBL[i][7:0]});
         wr(5'd3, 0); wr(5'd0, 0);
         take(v); wr(5'd3, 0); settle();
         rd(5'd0 + 5'd2, d); chk("R9 ppr idle", d, 32'h0);
      end

      // R6 highest first, R9 ppr from service, R8 retirement order
      post(8'h21, 1'b0); post(8'h85, 1'b0); post(8'h60, 1'b0);
      take(v); chk("R6 highest pending", {24'h0, v}, 32'h85);
      rd(5'd2, d); chk("R9 ppr from service", d, 32'h80);
      settle();
      chk("R4 irq blocked by class", {31'h0, irq}, 32'h0);
      take(v); chk("R6 next pending", {24'h0, v}, 32'h60);
      wr(5'd3, 0);
      rd(5'd2, d); chk("R8 eoi top first", d, 32'h60);
      rd(5'd20, d); chk("R8 service word4", d, 32'h0);
      rd(5'd19, d); chk("R8 service word3", d, 32'h0000_0001);
      wr(5'd3, 0); settle();
      chk("R4 irq after eoi", {31'h0, irq}, 32'h1);
      take(v); chk("R6 last pending", {24'h0, v}, 32'h21);
      wr(5'd3, 0);
      wr(5'd0, 32'h25);
      rd(5'd2, d); chk("R9 ppr task wins", d, 32'h25);
      wr(5'd0, 0);

      // R8 eoi with empty service leaves pending untouched
      post(8'hC3, 1'b0);
      wr(5'd3, 0);
      rd(5'd14, d); chk("R8 eoi empty pending", d, 32'h0000_0008);
      rd(5'd22, d); chk("R8 eoi empty service", d, 32'h0);
      take(v); wr(5'd3, 0);

      // R5 trigger marking
      post(8'h33, 1'b1);
      rd(5'd25, d); chk("R5 level trig", d, 32'h0008_0000);
      rd(5'd9, d);  chk("R5 pending set", d, 32'h0008_0000);
      post(8'h33, 1'b0);
      rd(5'd25, d); chk("R5 edge clears trig", d, 32'h0);
      take(v); wr(5'd3, 0);

      // R3 write widths
      wr(5'd1, 32'hFFFF_FFFF);
      rd(5'd1, d); chk("R3 spurious width", d, 32'h1FF);
      wr(5'd0, 32'h0000_1234);
      rd(5'd0, d); chk("R3 task width", d, 32'h34);
      rd(5'd3, d); chk("R2 eoi reads zero", d, 32'h0);
      wr(5'd0, 0);

      // R10 request and acknowledge together
      @(negedge clk); req_valid = 1; req_vec = 8'h90; req_level = 0; ack = 1;
      #1 v = ack_vec;
      @(posedge clk); #1 req_valid = 0; ack = 0;
      chk("R10 same-cycle ack", {24'h0, v}, 32'h90);
      rd(5'd12, d); chk("R10 pending cleared", d, 32'h0);
      rd(5'd20, d); chk("R10 in service", d, 32'h0001_0000);
      wr(5'd3, 0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule